// File: doc/BRIEF.md
# Synchronous Serial Slave Shift Unit

This block is the slave end of a three-wire synchronous serial link. An external master supplies the shift clock and an active-low select. The block samples the serial input and drives a serial output that floats whenever it is not selected. All shifting is done in the system clock domain. The clock, select and data pins pass through two-flop synchronisers, and both clock edges are detected after synchronisation. The block therefore suits links whose shift clock is several times slower than the system clock.

Software sees three registers. The data register holds the next transmit word when written and returns the received word when read. The control register selects the word length, enables echo and enables each interrupt. The status register reports busy, read-buffer-full and overrun. When echo is enabled and no fresh transmit word has been loaded, the block loops each received bit back onto its output. A single interrupt line combines the three enabled conditions.

Top module: `sync_serial_slave`

## Requirements
- R1: The serial output is high-impedance whenever the synchronised select is inactive, and is driven while the select is active.
- R2: Input bits are sampled only on rising shift-clock edges seen while the select is active. The output bit changes only after falling edges, or while no transfer is in progress.
- R3: Control bit 0 selects the word length: 0 gives 8 bits and 1 gives 16 bits. The value is taken at the first rising edge of a transfer. A transfer completes after exactly that many rising edges.
- R4: Bits travel most significant first. In 8-bit mode the block sends data bits 7..0 and in 16-bit mode bits 15..0. The received word sits right-aligned in the data register, with the upper byte reading zero in 8-bit mode.
- R5: Control bit 1 enables echo. If echo is set and no transmit word was written since the last transfer started, the output carries 0 before the first rising edge. After each later falling edge it carries the bit sampled at the preceding rising edge. The received word is still stored.
- R6: With echo clear, the block sends the data register contents even if they were already sent, so an unrefreshed word is sent again.
- R7: Releasing the select resets the bit counter. A partial transfer is discarded and does not set read-buffer-full.
- R8: Register addresses are 0 for data, 1 for control and 2 for status. The status bits are 0 busy, 1 read-buffer-full and 2 overrun. Writing the data register sets busy and marks the word valid. Busy clears when the next transfer completes.
- R9: At completion the received word is loaded and read-buffer-full is set, provided that flag was clear. Reading the data register returns the word and clears the flag.
- R10: If read-buffer-full is still set at completion, the word waits in the shifter. It moves to the read buffer once the buffer is read while the link is idle. If a new transfer starts while the word is waiting and the buffer is full, overrun is set. Writing 1 to status bit 2 clears overrun.
- R11: The interrupt is the OR of three terms: not busy with control bit 2, read-buffer-full with control bit 3, and overrun with control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Shift clock from the master |
| cs_n_i | input | 1 | Active-low select from the master |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master, high-impedance when deselected |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions watch the invariants that hold on every cycle. These are the bit counter staying below the latched length, the counter clearing after deselect, busy falling only on a completion, a read of a full buffer emptying it, and overrun staying set until it is cleared. Other behaviour can only be shown by whole scenarios that compare serial waveforms and register reads with bench-computed words. This covers bit order in both lengths, echo, resending a stale word, aborted transfers, the waiting word moving into the buffer, the transfer that causes an overrun, and interrupt gating.

// File: rtl/sss_pkg.sv
package sss_pkg;
    localparam int unsigned DATA_W = 16;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_STAT = 2'd2
    } sss_addr_e;

    // packed: first member is the most significant bit, len16 lands on bit 0
    typedef struct packed {
        logic ie_ovf;
        logic ie_rbf;
        logic ie_idle;
        logic echo;
        logic len16;
    } sss_ctrl_t;

    localparam int unsigned CTRL_W = $bits(sss_ctrl_t);
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
    parameter int unsigned         W      = 1,
    parameter int unsigned         STAGES = 2,
    parameter logic [W-1:0]        RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sss_shifter.sv
module sss_shifter #(
    parameter int unsigned DW = 16,
    localparam int unsigned HW = DW / 2,
    localparam int unsigned CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise_i,
    input  logic          sck_fall_i,
    input  logic          cs_act_i,
    input  logic          sdi_i,
    input  logic          len16_i,
    input  logic          echo_i,
    input  logic          txv_i,
    input  logic [DW-1:0] tx_word_i,
    output logic          start_o,
    output logic          done_o,
    output logic          idle_o,
    output logic [DW-1:0] word_o,
    output logic          sdo_o,
    output logic [CW-1:0] cnt_o,
    output logic          len_act_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] sr;
        logic          last_rx;
        logic          sdo;
        logic          echo_act;
        logic          len_act;
        logic          done;
    } shf_t;

    shf_t s_d, s_q;

    logic          len_eff;
    logic [CW-1:0] lim;
    logic [CW-1:0] nxt;
    logic          use_tx;
    logic [DW-1:0] src;
    logic          first_bit;
    logic          cur_bit;

    always_comb begin
        len_eff   = (s_q.cnt == '0) ? len16_i : s_q.len_act;
        lim       = len_eff ? CW'(DW) : CW'(HW);
        nxt       = s_q.cnt + CW'(1);
        use_tx    = txv_i || !echo_i;
        src       = use_tx ? tx_word_i : '0;
        first_bit = len16_i ? src[DW-1] : src[HW-1];
        cur_bit   = s_q.len_act ? s_q.sr[DW-1] : s_q.sr[HW-1];

        s_d      = s_q;
        s_d.done = 1'b0;

        if (!cs_act_i) begin
            s_d.cnt = '0;
        end else if (sck_rise_i) begin
            if (s_q.cnt == '0) begin
                s_d.echo_act = echo_i && !txv_i;
                s_d.len_act  = len16_i;
                s_d.sr       = {src[DW-2:0], sdi_i};
            end else begin
                s_d.sr = {s_q.sr[DW-2:0], sdi_i};
            end
            s_d.last_rx = sdi_i;
            if (nxt == lim) begin
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = nxt;
            end
        end else if (sck_fall_i && (s_q.cnt != '0)) begin
            s_d.sdo = s_q.echo_act ? s_q.last_rx : cur_bit;
        end else if (s_q.cnt == '0) begin
            s_d.sdo = first_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_o   = cs_act_i && sck_rise_i && (s_q.cnt == '0);
    assign done_o    = s_q.done;
    assign idle_o    = (s_q.cnt == '0);
    assign word_o    = s_q.len_act ? s_q.sr : {{(DW-HW){1'b0}}, s_q.sr[HW-1:0]};
    assign sdo_o     = s_q.sdo;
    assign cnt_o     = s_q.cnt;
    assign len_act_o = s_q.len_act;
endmodule

// File: rtl/sss_status.sv
module sss_status #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_data_i,
    input  logic          wr_data_i,
    input  logic          clr_ovf_i,
    input  logic          start_i,
    input  logic          done_i,
    input  logic          idle_i,
    input  logic [DW-1:0] word_i,
    input  logic          ie_idle_i,
    input  logic          ie_rbf_i,
    input  logic          ie_ovf_i,
    output logic [DW-1:0] rbuf_o,
    output logic          busy_o,
    output logic          rbf_o,
    output logic          ovf_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] rbuf;
        logic          busy;
        logic          rbf;
        logic          ovf;
        logic          held;
    } sts_t;

    sts_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        if (rd_data_i) s_d.rbf = 1'b0;
        if (clr_ovf_i) s_d.ovf = 1'b0;

        if (s_q.held && !s_q.rbf && idle_i) begin
            s_d.rbuf = word_i;
            s_d.rbf  = 1'b1;
            s_d.held = 1'b0;
        end else if (start_i && s_q.held) begin
            s_d.ovf  = 1'b1;
            s_d.held = 1'b0;
        end

        if (done_i) begin
            s_d.busy = 1'b0;
            if (!s_q.rbf) begin
                s_d.rbuf = word_i;
                s_d.rbf  = 1'b1;
            end else begin
                s_d.held = 1'b1;
            end
        end

        if (wr_data_i) s_d.busy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rbuf_o = s_q.rbuf;
    assign busy_o = s_q.busy;
    assign rbf_o  = s_q.rbf;
    assign ovf_o  = s_q.ovf;
    assign irq_o  = (!s_q.busy && ie_idle_i) || (s_q.rbf && ie_rbf_i) || (s_q.ovf && ie_ovf_i);
endmodule

// File: rtl/sync_serial_slave.sv
module sync_serial_slave
    import sss_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    localparam int unsigned CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          cs_n_i,
    input  logic          sdi_i,
    output logic          sdo_o,
    input  logic [1:0]    reg_addr_i,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o
);
    typedef struct packed {
        sss_ctrl_t     ctrl;
        logic [DW-1:0] dreg;
        logic          txv;
        logic          sck_prev;
    } top_t;

    top_t t_d, t_q;

    logic [2:0]    pins_s;
    logic          sck_s, cs_n_s, sdi_s;
    logic          cs_act, sck_rise, sck_fall;
    logic          wr_data, rd_data, wr_ctrl, clr_ovf;
    logic          start, done, idle, sdo_bit, len_act;
    logic [DW-1:0] word, rbuf;
    logic [CW-1:0] cnt;
    logic          busy, rbf, ovf;

    sss_sync #(.W(3), .STAGES(2), .RST(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_i, cs_n_i, sdi_i}),
        .q_o   (pins_s)
    );

    assign {sck_s, cs_n_s, sdi_s} = pins_s;
    assign cs_act   = !cs_n_s;
    assign sck_rise = sck_s && !t_q.sck_prev;
    assign sck_fall = !sck_s && t_q.sck_prev;

    assign wr_data = reg_wr_i && (reg_addr_i == ADDR_DATA);
    assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign clr_ovf = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[2];
    assign rd_data = reg_rd_i && (reg_addr_i == ADDR_DATA);

    always_comb begin
        t_d          = t_q;
        t_d.sck_prev = sck_s;
        if (start)   t_d.txv  = 1'b0;
        if (wr_data) begin
            t_d.dreg = reg_wdata_i;
            t_d.txv  = 1'b1;
        end
        if (wr_ctrl) t_d.ctrl = sss_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    sss_shifter #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .cs_act_i   (cs_act),
        .sdi_i      (sdi_s),
        .len16_i    (t_q.ctrl.len16),
        .echo_i     (t_q.ctrl.echo),
        .txv_i      (t_q.txv),
        .tx_word_i  (t_q.dreg),
        .start_o    (start),
        .done_o     (done),
        .idle_o     (idle),
        .word_o     (word),
        .sdo_o      (sdo_bit),
        .cnt_o      (cnt),
        .len_act_o  (len_act)
    );

    sss_status #(.DW(DW)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_data_i (rd_data),
        .wr_data_i (wr_data),
        .clr_ovf_i (clr_ovf),
        .start_i   (start),
        .done_i    (done),
        .idle_i    (idle),
        .word_i    (word),
        .ie_idle_i (t_q.ctrl.ie_idle),
        .ie_rbf_i  (t_q.ctrl.ie_rbf),
        .ie_ovf_i  (t_q.ctrl.ie_ovf),
        .rbuf_o    (rbuf),
        .busy_o    (busy),
        .rbf_o     (rbf),
        .ovf_o     (ovf),
        .irq_o     (irq_o)
    );

    assign sdo_o = cs_act ? sdo_bit : 1'bz;

    always_comb begin
        unique case (reg_addr_i)
            ADDR_DATA: reg_rdata_o = rbuf;
            ADDR_CTRL: reg_rdata_o = {{(DW-CTRL_W){1'b0}}, t_q.ctrl};
            ADDR_STAT: reg_rdata_o = {{(DW-3){1'b0}}, ovf, rbf, busy};
            default:   reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
    parameter int unsigned DW = 16,
    localparam int unsigned CW = $clog2(DW + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_act,
    input logic [CW-1:0] cnt,
    input logic          len_act,
    input logic          done,
    input logic          busy,
    input logic          rbf,
    input logic          ovf,
    input logic          rd_data,
    input logic          clr_ovf
);
    // R3: the bit counter never reaches the latched word length
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < (len_act ? CW'(DW) : CW'(DW / 2)));

    // R7: deselect clears the bit counter on the next cycle
    assert_cs_resync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0));

    // R8: busy only falls on a completed transfer
    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R9: reading a full buffer empties it
    assert_rbf_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rbf) |=> !rbf);

    // R10: overrun stays set until cleared by software
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);
endmodule

bind sync_serial_slave sss_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .cnt     (cnt),
    .len_act (len_act),
    .done    (done),
    .busy    (busy),
    .rbf     (rbf),
    .ovf     (ovf),
    .rd_data (rd_data),
    .clr_ovf (clr_ovf)
);

// File: tb/sync_serial_slave_tb.sv
module sync_serial_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    wire         sdo;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sync_serial_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .sdi_i(sdi), .sdo_o(sdo),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // master side: nclk bits of mosi MSB first, sdo captured just before each rising edge
    task automatic xfer(input int nclk, input logic [15:0] mosi, output logic [15:0] miso,
                        input bit release_cs);
        miso = 16'h0;
        cs_n = 1'b0;
        idle(8);
        for (int i = nclk - 1; i >= 0; i--) begin
            sdi = mosi[i];
            idle(8);
            miso[i] = sdo;
            sck = 1'b1;
            idle(8);
            sck = 1'b0;
        end
        idle(8);
        if (release_cs) cs_n = 1'b1;
        idle(6);
    endtask

    function automatic logic [15:0] exp_tx(bit l16, bit echo_act, logic [15:0] tx, logic [15:0] rx);
        logic [15:0] m;
        m = l16 ? 16'hFFFF : 16'h00FF;
        if (echo_act) return (rx & m) >> 1;
        return tx & m;
    endfunction

    function automatic logic [15:0] exp_rx(bit l16, logic [15:0] rx);
        return l16 ? rx : (rx & 16'h00FF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, cap, tx, rx, last_tx;
        bit l16, ech, do_wr;
        void'($urandom(32'h5EED_1234));

        idle(5);
        rst_n = 1'b1;
        idle(4);

        // reset state
        reg_rd(2'd2, d); chk("R8 reset status", d, 16'h0);
        reg_rd(2'd1, d); chk("R8 reset ctrl", d, 16'h0);
        chk("R1 reset sdo floats", {15'h0, sdo === 1'bz}, 16'h1);
        chk("R11 reset irq", {15'h0, irq}, 16'h0);

        // 8-bit: lower byte, MSB first
        reg_wr(2'd1, 16'h0000);
        reg_wr(2'd0, 16'h3CA5);
        reg_rd(2'd2, d); chk("R8 busy after write", d, 16'h1);
        xfer(8, 16'h005A, cap, 1'b1);
        chk("R4 8-bit tx bits", cap & 16'h00FF, 16'h00A5);
        chk("R1 sdo floats after release", {15'h0, sdo === 1'bz}, 16'h1);
        reg_rd(2'd2, d); chk("R9 rbf set, busy clear", d, 16'h2);
        reg_rd(2'd0, d); chk("R9 8-bit rx word", d, 16'h005A);
        reg_rd(2'd2, d); chk("R9 rbf cleared by read", d, 16'h0);

        // 16-bit
        reg_wr(2'd1, 16'h0001);
        reg_wr(2'd0, 16'hBEEF);
        xfer(16, 16'h1234, cap, 1'b1);
        chk("R3 R4 16-bit tx", cap, 16'hBEEF);
        reg_rd(2'd0, d); chk("R3 16-bit rx", d, 16'h1234);

        // stale word sent again with echo off
        xfer(16, 16'h0F0F, cap, 1'b1);
        chk("R6 stale word resent", cap, 16'hBEEF);
        reg_rd(2'd0, d); chk("R6 rx stored", d, 16'h0F0F);

        // echo with no valid word
        reg_wr(2'd1, 16'h0003);
        xfer(16, 16'h9C31, cap, 1'b1);
        chk("R5 echo loopback", cap, exp_tx(1, 1, 16'h0, 16'h9C31));
        reg_rd(2'd0, d); chk("R5 echo rx stored", d, 16'h9C31);

        // echo set but valid word present
        reg_wr(2'd0, 16'h0F0F);
        xfer(16, 16'h7777, cap, 1'b1);
        chk("R5 echo bypassed by valid word", cap, 16'h0F0F);
        reg_rd(2'd0, d); chk("R5 rx with valid word", d, 16'h7777);

        // aborted transfer then a clean one
        reg_wr(2'd1, 16'h0000);
        reg_wr(2'd0, 16'h00C3);
        xfer(5, 16'h001F, cap, 1'b1);
        chk("R7 floats after abort", {15'h0, sdo === 1'bz}, 16'h1);
        reg_rd(2'd2, d); chk("R7 no rbf after abort", d & 16'h2, 16'h0);
        reg_wr(2'd0, 16'h0096);
        xfer(8, 16'h00E1, cap, 1'b1);
        chk("R7 resync tx", cap & 16'h00FF, 16'h0096);
        reg_rd(2'd0, d); chk("R7 resync rx", d, 16'h00E1);

        // select held low across transfers (R2 shifting keyed to edges only)
        reg_wr(2'd0, 16'h0055);
        xfer(8, 16'h00AA, cap, 1'b0);
        chk("R2 tx with select held", cap & 16'h00FF, 16'h0055);
        reg_rd(2'd0, d); chk("R2 rx with select held", d, 16'h00AA);
        idle(40);
        reg_rd(2'd2, d); chk("R2 no shift without clock edges", d, 16'h0);
        cs_n = 1'b1; idle(6);

        // held word and overrun
        reg_wr(2'd1, 16'h0010);
        xfer(8, 16'h0011, cap, 1'b1);
        xfer(8, 16'h0022, cap, 1'b1);
        reg_rd(2'd2, d); chk("R10 held, no overrun yet", d, 16'h2);
        reg_rd(2'd0, d); chk("R10 first word", d, 16'h0011);
        idle(3);
        reg_rd(2'd2, d); chk("R10 held word moved", d, 16'h2);
        reg_rd(2'd0, d); chk("R10 moved word value", d, 16'h0022);
        xfer(8, 16'h0033, cap, 1'b1);
        xfer(8, 16'h0044, cap, 1'b1);
        chk("R11 irq before overrun", {15'h0, irq}, 16'h0);
        xfer(8, 16'h0055, cap, 1'b1);
        reg_rd(2'd2, d); chk("R10 overrun set", d, 16'h6);
        chk("R11 irq on overrun", {15'h0, irq}, 16'h1);
        reg_wr(2'd2, 16'h0004);
        reg_rd(2'd2, d); chk("R10 overrun cleared", d, 16'h2);
        chk("R11 irq off after clear", {15'h0, irq}, 16'h0);
        reg_rd(2'd0, d); chk("R10 buffer kept", d, 16'h0033);
        idle(3);
        reg_rd(2'd0, d); chk("R10 last word after overrun", d, 16'h0055);

        // interrupt gating
        reg_wr(2'd1, 16'h0004);
        idle(1); chk("R11 idle irq", {15'h0, irq}, 16'h1);
        reg_wr(2'd0, 16'h0001);
        idle(1); chk("R11 busy masks irq", {15'h0, irq}, 16'h0);
        reg_wr(2'd1, 16'h0008);
        xfer(8, 16'h0009, cap, 1'b1);
        chk("R11 rbf irq", {15'h0, irq}, 16'h1);
        reg_rd(2'd0, d);
        idle(1); chk("R11 rbf irq cleared", {15'h0, irq}, 16'h0);

        // constrained random
        last_tx = 16'h0001;
        for (int k = 0; k < 24; k++) begin
            l16   = $urandom_range(0, 1) != 0;
            ech   = $urandom_range(0, 1) != 0;
            do_wr = $urandom_range(0, 2) != 0;
            tx    = 16'($urandom());
            rx    = 16'($urandom());
            reg_wr(2'd1, {14'h0, ech, l16});
            if (do_wr) begin
                reg_wr(2'd0, tx);
                last_tx = tx;
            end
            xfer(l16 ? 16 : 8, rx, cap, 1'b1);
            chk(ech && !do_wr ? "R5 random echo" : "R4 random tx", cap,
                exp_tx(l16, ech && !do_wr, last_tx, rx));
            reg_rd(2'd0, d); chk("R9 random rx", d, exp_rx(l16, rx));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule